// File: doc/BRIEF.md
# Modulo-Scheduled Loop Branch Controller

This block holds the control state that a processor front end needs to run modulo-scheduled loops from a single loop body. It keeps a 64-bit loop counter, a 6-bit drain (epilogue) counter and three rotating bases: one for the integer register window, one for the floating-point window and one for the predicate window. Three combinational translators map virtual register indices onto physical indices through those bases. The register files use the physical indices.

When a counted-top branch resolves, the block decides whether the branch is taken and updates the counters. It moves all three bases down by one and reports the bit that enters the lowest rotating predicate. A 1 enters while iterations are still starting. A 0 enters while the drain counter empties the pipeline, so prologue, kernel and epilogue come out of the same code. A plain counted-loop branch is also supported: it counts down and branches but does not rotate. A synchronous clear sets the bases to zero, and two load ports write the counters.

Top module: `loop_rotate_ctrl`

## Requirements
- R1: After reset the loop count, drain count and all three bases are zero, and no branch output is active.
- R2: Rotating regions: integer and floating indices 32..127, with size 96; predicate indices 16..63, with size 48. A base is reported as a value in 0..size-1, so a base of -k reads as size-k. For a virtual index v at or above the region's low end, the physical index is low + ((v - low + base) mod size). An index below the region passes through unchanged.
- R3: A counted-top branch (`br_top_i`=1) with a nonzero loop count is taken, decrements the loop count and leaves the drain count unchanged. It asserts `pred_wr_o` with `pred_in_o`=1. In the next cycle all three bases are one lower, and 0 wraps to size-1.
- R4: A counted-top branch with loop count 0 and a nonzero drain count decrements the drain count and rotates the bases. It asserts `pred_wr_o` with `pred_in_o`=0. It is taken only when the drain count before the branch is greater than 1.
- R5: A counted-top branch with both counts 0 is not taken and does not assert `pred_wr_o`. It changes no count and no base.
- R6: A counted-loop branch (`br_top_i`=0) is taken exactly when the loop count is nonzero and then decrements it. It never rotates the bases, never asserts `pred_wr_o` and never changes the drain count.
- R7: `clear_i` sets all three bases to 0 in the next cycle, even when a rotating branch resolves in the same cycle.
- R8: `lc_load_i` and `ec_load_i` write their data in the next cycle. Each load takes priority over the counter update of a branch in the same cycle. The loop counter is 64 bits and counts down from all ones.
- R9: Loading loop count 3 and drain count 2 and then issuing counted-top branches gives the taken pattern 1,1,1,1,0 and the predicate pattern 1,1,1,0,0. After the fifth branch the drain count is 0 and every base reads as -5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of all rotating bases |
| lc_load_i | input | 1 | Load the loop counter |
| lc_data_i | input | 64 | Loop counter load value |
| ec_load_i | input | 1 | Load the drain counter |
| ec_data_i | input | 6 | Drain counter load value |
| br_valid_i | input | 1 | A loop branch resolves this cycle |
| br_top_i | input | 1 | 1 = counted-top (rotating), 0 = counted-loop |
| br_taken_o | output | 1 | Branch is taken |
| pred_wr_o | output | 1 | Bases rotate; a bit enters the lowest rotating predicate |
| pred_in_o | output | 1 | Bit entering the lowest rotating predicate |
| lc_o | output | 64 | Current loop count |
| ec_o | output | 6 | Current drain count |
| gr_base_o | output | 7 | Integer rotating base |
| fr_base_o | output | 7 | Floating rotating base |
| pr_base_o | output | 6 | Predicate rotating base |
| gr_virt_i | input | 7 | Integer virtual index |
| gr_phys_o | output | 7 | Integer physical index |
| fr_virt_i | input | 7 | Floating virtual index |
| fr_phys_o | output | 7 | Floating physical index |
| pr_virt_i | input | 6 | Predicate virtual index |
| pr_phys_o | output | 6 | Predicate physical index |

## Verification
The hardest case to reach is the drain phase. It only appears after the loop count has run out, and only the branch that takes the drain count from 1 to 0 falls through while still rotating. The stimulus loads small counts and walks a full prologue, kernel and epilogue one branch at a time. It then checks the translators at a base that has already wrapped. A separate sequence sets the loop count to zero with a drain count of exactly 1, so the fall-through with rotation shows up on its own, away from the earlier branches.

// File: rtl/loop_rot_pkg.sv
package loop_rot_pkg;
    typedef enum logic {
        BR_CLOOP = 1'b0,
        BR_CTOP  = 1'b1
    } br_kind_e;
endpackage

// File: rtl/rot_index_map.sv
module rot_index_map #(
    parameter int IDX_W = 7,
    parameter int LO    = 32,
    parameter int CNT   = 96,
    localparam int BW   = $clog2(CNT)
) (
    input  logic [IDX_W-1:0] virt_i,
    input  logic [BW-1:0]    base_i,
    output logic [IDX_W-1:0] phys_o
);
    localparam logic [IDX_W:0] LO_X  = (IDX_W+1)'(LO);
    localparam logic [IDX_W:0] CNT_X = (IDX_W+1)'(CNT);

    logic [IDX_W:0] virt_x;
    logic [IDX_W:0] sum;

    always_comb begin
        virt_x = {1'b0, virt_i};
        sum    = (virt_x - LO_X) + (IDX_W+1)'(base_i);
        if (sum >= CNT_X) begin
            sum = sum - CNT_X;
        end
        if (virt_x < LO_X) begin
            phys_o = virt_i;
        end else begin
            phys_o = IDX_W'(sum + LO_X);
        end
    end
endmodule

// File: rtl/loop_branch_eval.sv
module loop_branch_eval
    import loop_rot_pkg::*;
#(
    parameter int LC_W = 64,
    parameter int EC_W = 6
) (
    input  logic            valid_i,
    input  br_kind_e        kind_i,
    input  logic [LC_W-1:0] lc_i,
    input  logic [EC_W-1:0] ec_i,
    output logic            taken_o,
    output logic            rotate_o,
    output logic            pred_o,
    output logic [LC_W-1:0] lc_next_o,
    output logic [EC_W-1:0] ec_next_o
);
    logic lc_nz, ec_nz, ec_gt1;

    always_comb begin
        lc_nz     = |lc_i;
        ec_nz     = |ec_i;
        ec_gt1    = |ec_i[EC_W-1:1];
        taken_o   = 1'b0;
        rotate_o  = 1'b0;
        pred_o    = 1'b0;
        lc_next_o = lc_i;
        ec_next_o = ec_i;
        if (valid_i) begin
            if (kind_i == BR_CLOOP) begin
                if (lc_nz) begin
                    taken_o   = 1'b1;
                    lc_next_o = lc_i - LC_W'(1);
                end
            end else begin
                if (lc_nz) begin
                    taken_o   = 1'b1;
                    rotate_o  = 1'b1;
                    pred_o    = 1'b1;
                    lc_next_o = lc_i - LC_W'(1);
                end else if (ec_nz) begin
                    taken_o   = ec_gt1;
                    rotate_o  = 1'b1;
                    ec_next_o = ec_i - EC_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/loop_rotate_ctrl.sv
module loop_rotate_ctrl
    import loop_rot_pkg::*;
#(
    parameter int LC_W   = 64,
    parameter int EC_W   = 6,
    parameter int INT_W  = 7,
    parameter int INT_LO = 32,
    parameter int INT_N  = 96,
    parameter int PRD_W  = 6,
    parameter int PRD_LO = 16,
    parameter int PRD_N  = 48,
    localparam int IBW   = $clog2(INT_N),
    localparam int PBW   = $clog2(PRD_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             lc_load_i,
    input  logic [LC_W-1:0]  lc_data_i,
    input  logic             ec_load_i,
    input  logic [EC_W-1:0]  ec_data_i,
    input  logic             br_valid_i,
    input  logic             br_top_i,
    output logic             br_taken_o,
    output logic             pred_wr_o,
    output logic             pred_in_o,
    output logic [LC_W-1:0]  lc_o,
    output logic [EC_W-1:0]  ec_o,
    output logic [IBW-1:0]   gr_base_o,
    output logic [IBW-1:0]   fr_base_o,
    output logic [PBW-1:0]   pr_base_o,
    input  logic [INT_W-1:0] gr_virt_i,
    output logic [INT_W-1:0] gr_phys_o,
    input  logic [INT_W-1:0] fr_virt_i,
    output logic [INT_W-1:0] fr_phys_o,
    input  logic [PRD_W-1:0] pr_virt_i,
    output logic [PRD_W-1:0] pr_phys_o
);
    localparam logic [IBW-1:0] INT_TOP = IBW'(INT_N - 1);
    localparam logic [PBW-1:0] PRD_TOP = PBW'(PRD_N - 1);

    typedef struct packed {
        logic [LC_W-1:0] lc;
        logic [EC_W-1:0] ec;
        logic [IBW-1:0]  gr_base;
        logic [IBW-1:0]  fr_base;
        logic [PBW-1:0]  pr_base;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic            taken, rotate, pred_bit;
    logic [LC_W-1:0] lc_after;
    logic [EC_W-1:0] ec_after;

    loop_branch_eval #(.LC_W(LC_W), .EC_W(EC_W)) i_eval (
        .valid_i   (br_valid_i),
        .kind_i    (br_top_i ? BR_CTOP : BR_CLOOP),
        .lc_i      (st_q.lc),
        .ec_i      (st_q.ec),
        .taken_o   (taken),
        .rotate_o  (rotate),
        .pred_o    (pred_bit),
        .lc_next_o (lc_after),
        .ec_next_o (ec_after)
    );

    // integer and floating windows share geometry: one mapper each
    logic [INT_W-1:0] int_virt [2];
    logic [INT_W-1:0] int_phys [2];
    logic [IBW-1:0]   int_base [2];

    assign int_virt[0] = gr_virt_i;
    assign int_virt[1] = fr_virt_i;
    assign int_base[0] = st_q.gr_base;
    assign int_base[1] = st_q.fr_base;

    for (genvar g = 0; g < 2; g++) begin : g_int_map
        rot_index_map #(.IDX_W(INT_W), .LO(INT_LO), .CNT(INT_N)) i_map (
            .virt_i (int_virt[g]),
            .base_i (int_base[g]),
            .phys_o (int_phys[g])
        );
    end

    assign gr_phys_o = int_phys[0];
    assign fr_phys_o = int_phys[1];

    rot_index_map #(.IDX_W(PRD_W), .LO(PRD_LO), .CNT(PRD_N)) i_pr_map (
        .virt_i (pr_virt_i),
        .base_i (st_q.pr_base),
        .phys_o (pr_phys_o)
    );

    always_comb begin
        st_d    = st_q;
        st_d.lc = lc_after;
        st_d.ec = ec_after;
        if (rotate) begin
            st_d.gr_base = (st_q.gr_base == '0) ? INT_TOP : st_q.gr_base - IBW'(1);
            st_d.fr_base = (st_q.fr_base == '0) ? INT_TOP : st_q.fr_base - IBW'(1);
            st_d.pr_base = (st_q.pr_base == '0) ? PRD_TOP : st_q.pr_base - PBW'(1);
        end
        if (clear_i) begin
            st_d.gr_base = '0;
            st_d.fr_base = '0;
            st_d.pr_base = '0;
        end
        if (lc_load_i) begin
            st_d.lc = lc_data_i;
        end
        if (ec_load_i) begin
            st_d.ec = ec_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign br_taken_o = taken;
    assign pred_wr_o  = rotate;
    assign pred_in_o  = pred_bit;
    assign lc_o       = st_q.lc;
    assign ec_o       = st_q.ec;
    assign gr_base_o  = st_q.gr_base;
    assign fr_base_o  = st_q.fr_base;
    assign pr_base_o  = st_q.pr_base;
endmodule

// File: rtl/loop_rotate_ctrl_chk.sv
module loop_rotate_ctrl_chk #(
    parameter int LC_W  = 64,
    parameter int EC_W  = 6,
    parameter int INT_W = 7,
    parameter int IBW   = 7,
    parameter int PBW   = 6,
    parameter int INT_N = 96,
    parameter int PRD_N = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic             lc_load_i,
    input logic             ec_load_i,
    input logic             br_valid_i,
    input logic             br_top_i,
    input logic             br_taken_o,
    input logic             pred_wr_o,
    input logic             pred_in_o,
    input logic [LC_W-1:0]  lc_o,
    input logic [EC_W-1:0]  ec_o,
    input logic [IBW-1:0]   gr_base_o,
    input logic [PBW-1:0]   pr_base_o,
    input logic [INT_W-1:0] gr_virt_i,
    input logic [INT_W-1:0] gr_phys_o
);
    localparam logic [IBW-1:0]   I_TOP = IBW'(INT_N - 1);
    localparam logic [PBW-1:0]   P_TOP = PBW'(PRD_N - 1);
    localparam logic [INT_W-1:0] I_LO  = INT_W'(32);
    localparam logic [EC_W-1:0]  EC1   = EC_W'(1);

    // R2: a rotating virtual index never leaves the rotating region
    p_map_in_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gr_virt_i >= I_LO) |-> (gr_phys_o >= I_LO));

    // R3: counted-top with work left counts down and keeps the drain count
    p_top_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && br_top_i && (lc_o != '0) && !lc_load_i && !ec_load_i)
        |=> (lc_o == $past(lc_o) - LC_W'(1)) && (ec_o == $past(ec_o)));

    p_top_pred_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && br_top_i && (lc_o != '0)) |-> (br_taken_o && pred_wr_o && pred_in_o));

    p_rotate_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_wr_o && !clear_i) |=>
        (gr_base_o == (($past(gr_base_o) == '0) ? I_TOP : $past(gr_base_o) - IBW'(1))) &&
        (pr_base_o == (($past(pr_base_o) == '0) ? P_TOP : $past(pr_base_o) - PBW'(1))));

    // R4: drain phase injects zero and falls through on the last step
    p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && br_top_i && (lc_o == '0) && (ec_o != '0))
        |-> (pred_wr_o && !pred_in_o && (br_taken_o == (ec_o > EC1))));

    // R5: nothing left to do
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && br_top_i && (lc_o == '0) && (ec_o == '0))
        |-> (!br_taken_o && !pred_wr_o));

    // R6: counted-loop branch
    p_cloop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && !br_top_i) |-> ((br_taken_o == (lc_o != '0)) && !pred_wr_o));

    // R7: clear wins over rotation
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (gr_base_o == '0) && (pr_base_o == '0));

    // R1/R5: without a branch or clear the bases hold
    p_base_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid_i && !clear_i) |=> ($stable(gr_base_o) && $stable(pr_base_o)));
endmodule

bind loop_rotate_ctrl loop_rotate_ctrl_chk #(
    .LC_W(LC_W), .EC_W(EC_W), .INT_W(INT_W), .IBW(IBW), .PBW(PBW),
    .INT_N(INT_N), .PRD_N(PRD_N)
) i_chk (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .lc_load_i(lc_load_i),
    .ec_load_i(ec_load_i), .br_valid_i(br_valid_i), .br_top_i(br_top_i),
    .br_taken_o(br_taken_o), .pred_wr_o(pred_wr_o), .pred_in_o(pred_in_o),
    .lc_o(lc_o), .ec_o(ec_o), .gr_base_o(gr_base_o), .pr_base_o(pr_base_o),
    .gr_virt_i(gr_virt_i), .gr_phys_o(gr_phys_o)
);

// File: tb/test_loop_rotate_ctrl.sv
`timescale 1ns/1ps
module test_loop_rotate_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        lc_load_i = 1'b0;
    logic [63:0] lc_data_i = '0;
    logic        ec_load_i = 1'b0;
    logic [5:0]  ec_data_i = '0;
    logic        br_valid_i = 1'b0;
    logic        br_top_i = 1'b0;
    logic        br_taken_o, pred_wr_o, pred_in_o;
    logic [63:0] lc_o;
    logic [5:0]  ec_o;
    logic [6:0]  gr_base_o, fr_base_o;
    logic [5:0]  pr_base_o;
    logic [6:0]  gr_virt_i = '0, fr_virt_i = '0;
    logic [6:0]  gr_phys_o, fr_phys_o;
    logic [5:0]  pr_virt_i = '0;
    logic [5:0]  pr_phys_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    loop_rotate_ctrl i_loop_rotate_ctrl (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .lc_load_i(lc_load_i), .lc_data_i(lc_data_i),
        .ec_load_i(ec_load_i), .ec_data_i(ec_data_i),
        .br_valid_i(br_valid_i), .br_top_i(br_top_i),
        .br_taken_o(br_taken_o), .pred_wr_o(pred_wr_o), .pred_in_o(pred_in_o),
        .lc_o(lc_o), .ec_o(ec_o),
        .gr_base_o(gr_base_o), .fr_base_o(fr_base_o), .pr_base_o(pr_base_o),
        .gr_virt_i(gr_virt_i), .gr_phys_o(gr_phys_o),
        .fr_virt_i(fr_virt_i), .fr_phys_o(fr_phys_o),
        .pr_virt_i(pr_virt_i), .pr_phys_o(pr_phys_o)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // ends a cycle: inputs change after the rising edge
    task automatic tick();
        @(posedge clk);
        #1;
        clear_i = 0; lc_load_i = 0; ec_load_i = 0; br_valid_i = 0;
    endtask

    task automatic load_counts(input logic [63:0] lc, input logic [5:0] ec);
        @(negedge clk);
        lc_load_i = 1; lc_data_i = lc; ec_load_i = 1; ec_data_i = ec;
        tick();
    endtask

    task automatic branch(input logic top, input logic e_taken, input logic e_wr,
                          input logic e_pred, input string req);
        @(negedge clk);
        br_valid_i = 1; br_top_i = top;
        #1;
        chk({req, " taken"}, 64'(br_taken_o), 64'(e_taken));
        chk({req, " pred_wr"}, 64'(pred_wr_o), 64'(e_wr));
        if (e_wr) chk({req, " pred_in"}, 64'(pred_in_o), 64'(e_pred));
        tick();
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        chk("R1 lc", lc_o, 0);
        chk("R1 ec", 64'(ec_o), 0);
        chk("R1 gr base", 64'(gr_base_o), 0);
        chk("R1 fr base", 64'(fr_base_o), 0);
        chk("R1 pr base", 64'(pr_base_o), 0);
        chk("R1 taken", 64'(br_taken_o), 0);
        gr_virt_i = 7'd45; pr_virt_i = 6'd30;
        #1;
        chk("R2 identity gr", 64'(gr_phys_o), 45);
        chk("R2 identity pr", 64'(pr_phys_o), 30);
    endtask

    task automatic t_pipeline_r9();
        bit exp_t [5] = '{1, 1, 1, 1, 0};
        bit exp_p [5] = '{1, 1, 1, 0, 0};
        load_counts(64'd3, 6'd2);
        for (int i = 0; i < 5; i++) begin
            branch(1'b1, exp_t[i], 1'b1, exp_p[i], (i < 3) ? "R9/R3" : "R9/R4");
        end
        @(negedge clk);
        chk("R9 ec", 64'(ec_o), 0);
        chk("R9 lc", lc_o, 0);
        chk("R9 gr base -5", 64'(gr_base_o), 91);
        chk("R9 fr base -5", 64'(fr_base_o), 91);
        chk("R9 pr base -5", 64'(pr_base_o), 43);
        gr_virt_i = 7'd32; fr_virt_i = 7'd127; pr_virt_i = 6'd16;
        #1;
        chk("R2 gr 32", 64'(gr_phys_o), 123);
        chk("R2 fr 127", 64'(fr_phys_o), 122);
        chk("R2 pr 16", 64'(pr_phys_o), 59);
        gr_virt_i = 7'd40; pr_virt_i = 6'd20;
        #1;
        chk("R2 gr 40 wraps", 64'(gr_phys_o), 35);
        chk("R2 pr 20", 64'(pr_phys_o), 63);
        gr_virt_i = 7'd10; pr_virt_i = 6'd21;
        #1;
        chk("R2 gr static", 64'(gr_phys_o), 10);
        chk("R2 pr 21 wraps", 64'(pr_phys_o), 16);
        pr_virt_i = 6'd5;
        #1;
        chk("R2 pr static", 64'(pr_phys_o), 5);
    endtask

    task automatic t_idle_r5();
        branch(1'b1, 1'b0, 1'b0, 1'b0, "R5");
        @(negedge clk);
        chk("R5 gr base held", 64'(gr_base_o), 91);
        chk("R5 pr base held", 64'(pr_base_o), 43);
        chk("R5 lc", lc_o, 0);
        chk("R5 ec", 64'(ec_o), 0);
    endtask

    task automatic t_clear_r7();
        load_counts(64'd1, 6'd0);
        @(negedge clk);
        clear_i = 1; br_valid_i = 1; br_top_i = 1;
        #1;
        chk("R7 rotating branch", 64'(pred_wr_o), 1);
        tick();
        @(negedge clk);
        chk("R7 gr base", 64'(gr_base_o), 0);
        chk("R7 fr base", 64'(fr_base_o), 0);
        chk("R7 pr base", 64'(pr_base_o), 0);
        chk("R7 lc still counted", lc_o, 0);
        load_counts(64'd1, 6'd0);
        branch(1'b1, 1'b1, 1'b1, 1'b1, "R3");
        @(negedge clk);
        chk("R3 gr base -1", 64'(gr_base_o), 95);
        chk("R3 pr base -1", 64'(pr_base_o), 47);
        gr_virt_i = 7'd32; pr_virt_i = 6'd16;
        #1;
        chk("R2 gr 32 at -1", 64'(gr_phys_o), 127);
        chk("R2 pr 16 at -1", 64'(pr_phys_o), 63);
    endtask

    task automatic t_cloop_r6();
        load_counts(64'd2, 6'd3);
        branch(1'b0, 1'b1, 1'b0, 1'b0, "R6");
        @(negedge clk); chk("R6 lc 1", lc_o, 1);
        branch(1'b0, 1'b1, 1'b0, 1'b0, "R6");
        @(negedge clk); chk("R6 lc 0", lc_o, 0);
        branch(1'b0, 1'b0, 1'b0, 1'b0, "R6");
        @(negedge clk);
        chk("R6 lc stays 0", lc_o, 0);
        chk("R6 ec unchanged", 64'(ec_o), 3);
        chk("R6 no rotation", 64'(gr_base_o), 95);
    endtask

    task automatic t_loads_r8();
        load_counts(64'hFFFF_FFFF_FFFF_FFFF, 6'd0);
        branch(1'b0, 1'b1, 1'b0, 1'b0, "R8");
        @(negedge clk);
        chk("R8 64-bit countdown", lc_o, 64'hFFFF_FFFF_FFFF_FFFE);
        @(negedge clk);
        br_valid_i = 1; br_top_i = 0; lc_load_i = 1; lc_data_i = 64'd5;
        tick();
        @(negedge clk);
        chk("R8 lc load wins", lc_o, 5);
        @(negedge clk);
        br_valid_i = 1; br_top_i = 1; ec_load_i = 1; ec_data_i = 6'd1;
        tick();
        @(negedge clk);
        chk("R8 ec load with branch", 64'(ec_o), 1);
        chk("R3 lc after top", lc_o, 4);
        @(negedge clk);
        lc_load_i = 1; lc_data_i = 64'd0;
        tick();
        branch(1'b1, 1'b0, 1'b1, 1'b0, "R4 last drain");
        @(negedge clk);
        chk("R4 ec reaches 0", 64'(ec_o), 0);
        chk("R4 still rotated", 64'(gr_base_o), 93);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset_r1();
        t_pipeline_r9();
        t_idle_r5();
        t_clear_r7();
        t_cloop_r6();
        t_loads_r8();
        summary();
    end
endmodule